// File: doc/BRIEF.md
# Local TDM Clock and Frame-Pulse Generator

This block derives the timing of a local time-division-multiplexed port from the frame boundary of a backplane port. A backplane aligner gives it a one-cycle strobe at each backplane frame boundary, together with the backplane line rate. After a fixed delay that depends on that rate, the block starts a local frame. It produces three local bit clocks (4.096, 8.192 and 16.384 MHz) and three 8 kHz frame pulses, one matched to each clock.

The block runs entirely in a 65.536 MHz system clock domain. Each local clock is a bit of a free-running divider. A backplane clock period is 8 system cycles. At every local boundary the divider is re-zeroed, so all three clocks fall on the same system edge. Each frame pulse covers one period of its own clock and is centred on the boundary: half of the pulse comes before the boundary and half after it. Each pulse has its own polarity bit, and the 8 MHz clock can be inverted. These controls are sampled only at defined moments, so no runt pulse can appear.

Top module: `lfg_local_timing`

## Requirements
- R1: The divider counts 16 system cycles per turn. `clk16_o` has a period of 4 cycles, `clk8_o` a period of 8 and `clk4_o` a period of 16, each high for half of its period. The divider runs freely whether or not a boundary has been seen.
- R2: On the system edge that forms the local boundary, the divider returns to zero and all three clocks go low (`clk8_o` goes low only when it is not inverted). After that edge they continue as in R1.
- R3: The local boundary falls on the edge exactly 144 system edges after the edge that samples `bp_sync` high with `bp_fast`=0 (18 backplane clock periods). With `bp_fast`=1 the distance is 112 edges (14 periods).
- R4: Relative to the boundary edge, each pulse is active for one period of its clock: 4 cycles for `fp16_o`, 8 for `fp8_o` and 16 for `fp4_o`. Half of those cycles come just before the boundary edge and half start at it.
- R5: Each pulse has a polarity bit: 0 gives an active-low pulse (idle high) and 1 gives an active-high pulse (idle low).
- R6: `c8_inv`=1 inverts `clk8_o`. The bit is sampled only on a local boundary edge, except before the first boundary, when it takes effect on the next edge.
- R7: Before the first `bp_sync` after reset, all three pulses remain at their inactive level, and that level follows the live polarity bits one edge later.
- R8: From the first `bp_sync` onward, the polarity bits are sampled only on edges that accept a `bp_sync`. Changes at any other time have no effect on the pulses until the next accepted strobe.
- R9: A `bp_sync` that arrives while a boundary is still pending replaces it. The boundary is rescheduled from the new strobe, and the earlier one produces neither a realignment nor a pulse.
- R10: While `rst_n` is low at a clock edge, all clocks are low and all pulses are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 65.536 MHz system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bp_sync | input | 1 | One-cycle strobe at the backplane frame boundary |
| bp_fast | input | 1 | Backplane rate: 0 = 16.384 Mb/s, 1 = 32.768 Mb/s |
| fp16_pol | input | 1 | Polarity of `fp16_o` (1 = active high) |
| fp8_pol | input | 1 | Polarity of `fp8_o` (1 = active high) |
| fp4_pol | input | 1 | Polarity of `fp4_o` (1 = active high) |
| c8_inv | input | 1 | Inverts `clk8_o` when 1 |
| clk16_o | output | 1 | 16.384 MHz local clock |
| clk8_o | output | 1 | 8.192 MHz local clock |
| clk4_o | output | 1 | 4.096 MHz local clock |
| fp16_o | output | 1 | Frame pulse matched to `clk16_o` |
| fp8_o | output | 1 | Frame pulse matched to `clk8_o` |
| fp4_o | output | 1 | Frame pulse matched to `clk4_o` |

## Verification
Every output is compared on every cycle, so an error shows up at the ports quickly:
- A divider phase error shows on `clk16_o` within two cycles.
- An off-by-one in the countdown moves the leading half of `fp16_o`, which is visible two cycles before the boundary.
- A stuck trailing flag or a mis-latched polarity corrupts the pulse level on the very next edge.

Strobes in both rate modes, a restart while a boundary is pending, and control changes during a countdown make each wrong state reach a port within one local frame.

// File: rtl/lfg_pkg.sv
// Package: shared constants and helpers for the local timing generator.
// Assumes the system clock is eight times the backplane bit clock.
package lfg_pkg;

    typedef enum logic {
        BP_RATE_16M = 1'b0,
        BP_RATE_32M = 1'b1
    } bp_rate_e;

    // Convert an offset in backplane clock periods into system cycles.
    function automatic int offset_cycles(input int bp_periods, input int sys_per_bp);
        return bp_periods * sys_per_bp;
    endfunction

endpackage

// File: rtl/lfg_offset_timer.sv
// Offset timer: counts from a backplane boundary strobe down to the local
// boundary. Raises 'fire' on the edge that forms the local boundary and
// exposes its next-state values so that pulse shapers can start their
// leading half ahead of that edge. A new strobe always reloads the count.
module lfg_offset_timer
    import lfg_pkg::*;
#(
    parameter int REM_W    = 8,
    parameter int SLOW_CYC = 144,
    parameter int FAST_CYC = 112
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bp_sync,
    input  logic             bp_fast,
    output logic             fire,
    output logic             busy_nxt,
    output logic [REM_W-1:0] rem_nxt
);

    localparam logic [REM_W-1:0] SLOW_LD = REM_W'(SLOW_CYC);
    localparam logic [REM_W-1:0] FAST_LD = REM_W'(FAST_CYC);

    logic             busy_q;
    logic [REM_W-1:0] rem_q;
    bp_rate_e         rate;

    assign rate = bp_rate_e'(bp_fast);

    // Next-state of the countdown: reload, expire, or step down.
    always_comb begin
        fire     = busy_q && (rem_q == REM_W'(1));
        busy_nxt = busy_q;
        rem_nxt  = rem_q;
        if (bp_sync) begin
            busy_nxt = 1'b1;
            rem_nxt  = (rate == BP_RATE_32M) ? FAST_LD : SLOW_LD;
        end else if (fire) begin
            busy_nxt = 1'b0;
            rem_nxt  = '0;
        end else if (busy_q) begin
            rem_nxt  = rem_q - REM_W'(1);
        end
    end

    // Countdown registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            rem_q  <= '0;
        end else begin
            busy_q <= busy_nxt;
            rem_q  <= rem_nxt;
        end
    end

    // The count falls by one per cycle while pending and not reloaded.
    assert_countdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !bp_sync && rem_q != REM_W'(1)) |=> (busy_q && rem_q == $past(rem_q) - REM_W'(1)));

endmodule

// File: rtl/lfg_clock_divider.sv
// Clock divider: a free-running binary counter whose upper bits are the
// local clocks. It is re-zeroed on the boundary edge so that every clock
// falls together there. The next-state value feeds the pulse shapers.
module lfg_clock_divider #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    output logic [DIV_W-1:0] div_q,
    output logic [DIV_W-1:0] div_nxt
);

    // Realign on the boundary, otherwise advance.
    always_comb begin
        div_nxt = fire ? '0 : div_q + DIV_W'(1);
    end

    // Divider register.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_nxt;
    end

    // Away from a boundary the divider only ever steps by one.
    assert_clock_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> (div_q == $past(div_q) + DIV_W'(1)));

endmodule

// File: rtl/lfg_pulse_shaper.sv
// Pulse shaper: one frame pulse of width 2*HALF system cycles, centred on
// the local boundary edge. The leading half is taken from the timer's
// next-state; the trailing half from a flag set at the boundary and cleared
// when the divider wraps. Polarity is sampled live until the first strobe,
// then only on accepted strobes.
module lfg_pulse_shaper #(
    parameter int HALF  = 2,
    parameter int REM_W = 8,
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bp_sync,
    input  logic             pol_in,
    input  logic             fire,
    input  logic             busy_nxt,
    input  logic [REM_W-1:0] rem_nxt,
    input  logic [DIV_W-1:0] div_nxt,
    output logic             fp_o
);

    localparam int RUN_W = $clog2(2 * HALF + 2);

    logic seen_q, pol_q, trail_q, act_q;
    logic pol_nxt, trail_nxt, act_nxt;
    logic [RUN_W-1:0] run_q;

    // Decide polarity, trailing window and pulse activity for the next cycle.
    always_comb begin
        pol_nxt   = (bp_sync || !seen_q) ? pol_in : pol_q;
        trail_nxt = fire || (trail_q && (div_nxt != '0));
        act_nxt   = (busy_nxt && (rem_nxt != '0) && (rem_nxt <= REM_W'(HALF)))
                 || (trail_nxt && (div_nxt < DIV_W'(HALF)));
    end

    // Pulse state and registered output level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q  <= 1'b0;
            pol_q   <= 1'b0;
            trail_q <= 1'b0;
            act_q   <= 1'b0;
            fp_o    <= 1'b1;
        end else begin
            seen_q  <= seen_q | bp_sync;
            pol_q   <= pol_nxt;
            trail_q <= trail_nxt;
            act_q   <= act_nxt;
            fp_o    <= act_nxt ? pol_nxt : ~pol_nxt;
        end
    end

    // Checker counter: length of the current active run.
    always_ff @(posedge clk) begin
        if (!rst_n)     run_q <= '0;
        else if (act_q) run_q <= run_q + RUN_W'(1);
        else            run_q <= '0;
    end

    assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_W'(2 * HALF));

    assert_quiet_before_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> !act_q);

endmodule

// File: rtl/lfg_local_timing.sv
// Top: local TDM clock and frame-pulse generator. Schedules the local
// boundary after a rate-dependent offset from the backplane strobe, divides
// the system clock into three local clocks and shapes three frame pulses.
// Assumes a 65.536 MHz system clock and a one-cycle bp_sync strobe.
module lfg_local_timing
    import lfg_pkg::*;
#(
    parameter int SYS_PER_BP = 8,
    parameter int OFF_SLOW   = 18,
    parameter int OFF_FAST   = 14,
    parameter int DIV_W      = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bp_sync,
    input  logic bp_fast,
    input  logic fp16_pol,
    input  logic fp8_pol,
    input  logic fp4_pol,
    input  logic c8_inv,
    output logic clk16_o,
    output logic clk8_o,
    output logic clk4_o,
    output logic fp16_o,
    output logic fp8_o,
    output logic fp4_o
);

    localparam int SLOW_CYC = offset_cycles(OFF_SLOW, SYS_PER_BP);
    localparam int FAST_CYC = offset_cycles(OFF_FAST, SYS_PER_BP);
    localparam int MAX_CYC  = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC;
    localparam int REM_W    = $clog2(MAX_CYC + 1);
    localparam int N_PULSE  = 3;

    logic             fire, busy_nxt;
    logic [REM_W-1:0] rem_nxt;
    logic [DIV_W-1:0] div_q, div_nxt;
    logic             synced_q, inv_q;
    logic [N_PULSE-1:0] pol_vec, fp_vec;

    lfg_offset_timer #(
        .REM_W(REM_W), .SLOW_CYC(SLOW_CYC), .FAST_CYC(FAST_CYC)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .bp_sync(bp_sync), .bp_fast(bp_fast),
        .fire(fire), .busy_nxt(busy_nxt), .rem_nxt(rem_nxt)
    );

    lfg_clock_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .fire(fire),
        .div_q(div_q), .div_nxt(div_nxt)
    );

    // Index 0: 16 MHz pulse, 1: 8 MHz pulse, 2: 4 MHz pulse.
    assign pol_vec = {fp4_pol, fp8_pol, fp16_pol};

    for (genvar i = 0; i < N_PULSE; i++) begin : g_pulse
        lfg_pulse_shaper #(
            .HALF(1 << (DIV_W - 3 + i)), .REM_W(REM_W), .DIV_W(DIV_W)
        ) u_shaper (
            .clk(clk), .rst_n(rst_n), .bp_sync(bp_sync), .pol_in(pol_vec[i]),
            .fire(fire), .busy_nxt(busy_nxt), .rem_nxt(rem_nxt),
            .div_nxt(div_nxt), .fp_o(fp_vec[i])
        );
    end

    // 8 MHz inversion control: live until the first boundary, then per boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            synced_q <= 1'b0;
            inv_q    <= 1'b0;
        end else begin
            synced_q <= synced_q | fire;
            if (fire || !synced_q) inv_q <= c8_inv;
        end
    end

    assign clk16_o = div_q[DIV_W-3];
    assign clk8_o  = div_q[DIV_W-2] ^ inv_q;
    assign clk4_o  = div_q[DIV_W-1];
    assign fp16_o  = fp_vec[0];
    assign fp8_o   = fp_vec[1];
    assign fp4_o   = fp_vec[2];

    // All clocks fall together at the boundary; 8 MHz follows the sampled inversion.
    assert_common_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (!clk16_o && !clk4_o && (clk8_o == $past(c8_inv))));

    assert_inv_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (synced_q && !fire) |=> (inv_q == $past(inv_q)));

endmodule

// File: tb/lfg_local_timing_test.sv
// Bench: behavioural edge-indexed reference model compared on every cycle.
module lfg_local_timing_test;

    localparam int SLOW = 144;
    localparam int FAST = 112;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bp_sync = 1'b0, bp_fast = 1'b0, c8_inv = 1'b0;
    logic [2:0] pol = 3'b000;
    logic clk16_o, clk8_o, clk4_o, fp16_o, fp8_o, fp4_o;

    int total = 0, bad = 0;
    string cur_req = "R10";
    bit chk_on = 0, done = 0;

    // reference model state
    int e = 0, anchor = 0, bnd = 0, last_bnd = -1000;
    bit sched = 0, seen = 0, synced = 0, inv_l = 0;
    bit [2:0] pol_l = 0;
    bit x16, x8, x4;
    bit [2:0] xfp;

    always #5 clk = ~clk;

    lfg_local_timing uut (
        .clk(clk), .rst_n(rst_n), .bp_sync(bp_sync), .bp_fast(bp_fast),
        .fp16_pol(pol[0]), .fp8_pol(pol[1]), .fp4_pol(pol[2]), .c8_inv(c8_inv),
        .clk16_o(clk16_o), .clk8_o(clk8_o), .clk4_o(clk4_o),
        .fp16_o(fp16_o), .fp8_o(fp8_o), .fp4_o(fp4_o)
    );

    // Model update at every edge, from the requirements.
    always @(posedge clk) begin
        int ph;
        e++;
        if (!rst_n) begin
            anchor = e; sched = 0; seen = 0; synced = 0;
            pol_l = 0; inv_l = 0; last_bnd = -1000;
        end else begin
            if (sched && e == bnd) begin
                last_bnd = e; anchor = e; sched = 0; inv_l = c8_inv; synced = 1;
            end
            if (bp_sync) begin
                sched = 1; bnd = e + (bp_fast ? FAST : SLOW);
            end
            if (bp_sync || !seen) pol_l = pol;
            seen = seen | bp_sync;
            if (!synced) inv_l = c8_inv;
        end
        ph  = (e - anchor) % 16;
        x16 = ((ph >> 1) & 1) != 0;
        x8  = (((ph >> 2) & 1) != 0) ^ inv_l;
        x4  = ((ph >> 3) & 1) != 0;
        for (int i = 0; i < 3; i++) begin
            int h;
            bit act;
            h   = 2 << i;
            act = (sched && (bnd - e) >= 1 && (bnd - e) <= h) || ((e - last_bnd) < h);
            xfp[i] = act ? pol_l[i] : ~pol_l[i];
        end
    end

    task automatic chk(input string nm, input logic a, input logic x);
        total++;
        if (a !== x) begin
            bad++;
            $display("FAIL %s %s at edge %0d: actual=%0b expected=%0b", cur_req, nm, e, a, x);
        end
    endtask

    // Compare away from the active edge.
    always @(negedge clk) begin
        if (chk_on && !done) begin
            chk("clk16_o", clk16_o, x16);
            chk("clk8_o",  clk8_o,  x8);
            chk("clk4_o",  clk4_o,  x4);
            chk("fp16_o",  fp16_o,  xfp[0]);
            chk("fp8_o",   fp8_o,   xfp[1]);
            chk("fp4_o",   fp4_o,   xfp[2]);
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(input bit fast);
        bp_fast = fast;
        bp_sync = 1'b1;
        @(negedge clk);
        bp_sync = 1'b0;
    endtask

    initial begin
        wait_n(3);
        // R10: reset state
        cur_req = "R10";
        chk("clk16_o", clk16_o, 1'b0);
        chk("clk8_o",  clk8_o,  1'b0);
        chk("clk4_o",  clk4_o,  1'b0);
        chk("fp16_o",  fp16_o,  1'b1);
        chk("fp8_o",   fp8_o,   1'b1);
        chk("fp4_o",   fp4_o,   1'b1);
        rst_n = 1'b1;
        chk_on = 1;
        // R7 and R1: free-running clocks, quiet pulses following live polarity
        cur_req = "R7 R1 idle";
        wait_n(40);
        pol = 3'b101; c8_inv = 1'b1;
        wait_n(20);
        pol = 3'b000; c8_inv = 1'b0;
        wait_n(5);
        // R3 R2 R4: slow-rate offset and centred pulses
        cur_req = "R3 R2 R4 slow";
        strobe(1'b0);
        wait_n(200);
        // R3 R5: fast-rate offset with active-high pulses
        cur_req = "R3 R5 fast";
        pol = 3'b111;
        strobe(1'b1);
        wait_n(200);
        // R8 R6: controls changed mid-countdown
        cur_req = "R8 R6 late controls";
        pol = 3'b000;
        strobe(1'b0);
        wait_n(30);
        pol = 3'b111; c8_inv = 1'b1;
        wait_n(200);
        cur_req = "R8 R5 relatched";
        pol = 3'b010;
        strobe(1'b1);
        wait_n(200);
        // R9: restart while pending
        cur_req = "R9 restart";
        c8_inv = 1'b0;
        strobe(1'b0);
        wait_n(60);
        strobe(1'b1);
        wait_n(250);
        cur_req = "R1 free run";
        wait_n(100);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL R10 watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule